// File: doc/BRIEF.md
# Banked Address Translator with Register Window

This block sits between the address field of an instruction and the memories of a small 16-bit accumulator machine. The 12-bit field can name only 4096 locations, while the machine holds 2K words of erasable store and 36K words of fixed store. The translator extends the field with three bank values held in flip-flops and turns it into one physical address plus a region code.

The block also holds the handful of flip-flop registers that software sees as the lowest memory locations: two accumulator halves, a return-address word, a next-address word, the erasable bank word, the fixed bank word, a combined bank word that reads and writes both bank values at once, and a word that carries the bank-extension bit. A write strobe with 16-bit data updates these registers. Reads of them appear on a registered data output.

Each cycle the caller presents an address. One clock later the block returns the physical address, the region, and, for register locations, the register contents. Translation always uses the bank values held before that clock edge.

Top module: `bank_xlate`

## Requirements
- R1: Outputs are registered. The values seen after clock edge n describe the address present at edge n, and a new address can be presented every cycle.
- R2: Addresses 8 to 767 give region 1 (erasable) with a physical address equal to the address, whatever the bank values are.
- R3: Addresses 768 to 1023 give region 1 with a physical address of erasable_bank*256 + (address mod 256), where erasable_bank is 3 bits.
- R4: Addresses 1024 to 2047 give region 2 (fixed) with a physical address of fixed_bank*1024 + (address mod 1024) whenever the extension bit is 0 or fixed_bank is below 28.
- R5: When the extension bit is 1 and fixed_bank is 28 to 31, the window at 1024 to 2047 maps to banks 32 to 35, so the physical address is (fixed_bank+4)*1024 + (address mod 1024).
- R6: Addresses 2048 to 4095 give region 2 with a physical address equal to the address (fixed banks 2 and 3), unaffected by any bank value.
- R7: Addresses 0 to 7 give region 0 (register) with a physical address equal to the address. Region code 3 never appears.
- R8: Reset (synchronous, active high) clears all eight registers, the bank values and the extension bit. It also drives the outputs to a physical address of 0, region 0 and read data of 0.
- R9: A register location returns its contents on the read data output. Location 0 is A, 1 is L, 2 is Q and 5 is Z, each a full 16-bit word. Location 3 holds the erasable bank in bits 10:8. Location 4 holds the fixed bank in bits 14:10. Location 6 holds the fixed bank in bits 14:10 and the erasable bank in bits 2:0. Location 7 holds the extension bit in bit 6. All other bits read 0, and read data is 0 outside region 0.
- R10: A write to location 6 sets both bank values from bits 14:10 and 2:0 in one cycle. A write to location 3 or 4 changes only its own bank value, and location 6 then reads both.
- R11: A write strobe at any address of 8 or above changes no register or bank value.
- R12: A register write takes effect at the clock edge. A read of the same location in the same cycle returns the old contents, and the new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | 12 | Instruction address field |
| wr_en | input | 1 | Write strobe for register locations |
| wr_data | input | 16 | Write data |
| phys_addr | output | 16 | Translated physical address (erasable addresses zero-extended) |
| region | output | 2 | 0 register, 1 erasable, 2 fixed |
| rd_data | output | 16 | Register contents for region 0, otherwise 0 |

## Verification
The assertions check on every cycle the parts of the mapping that depend only on the previous address: the identity mapping of the unswitched erasable, register and fixed-fixed ranges, the kept offset bits of both switched windows, the region codes, the reset values and zero read data outside the register range. The exact bank substitution, the extension-bit boundary between codes 27 and 28, the field packing of the combined bank word, ignored writes and the old-value read in a write cycle all depend on the write history. Only the bench's scoreboard shows these, because it sweeps every bank setting and checks each result against a reference mapping.

// File: rtl/bx_pkg.sv
package bx_pkg;
  parameter int ADDR_W   = 12;
  parameter int DATA_W   = 16;
  parameter int PHYS_W   = 16;
  parameter int EB_W     = 3;
  parameter int FB_W     = 5;
  parameter int OFS_W    = 10;
  parameter int EOFS_W   = 8;
  parameter int NREG     = 8;
  parameter int N_FBANKS = 36;

  localparam int REG_AW = $clog2(NREG);

  // register locations; the mapping of software-visible words depends on these
  localparam int IX_A  = 0;
  localparam int IX_L  = 1;
  localparam int IX_Q  = 2;
  localparam int IX_EB = 3;
  localparam int IX_FB = 4;
  localparam int IX_Z  = 5;
  localparam int IX_BB = 6;
  localparam int IX_SB = 7;

  // field positions inside register words
  localparam int EB_LSB    = 8;
  localparam int FB_LSB    = 10;
  localparam int BB_EB_LSB = 0;
  localparam int BB_FB_LSB = 10;
  localparam int SB_POS    = 6;

  typedef enum logic [1:0] {
    RGN_REG   = 2'd0,
    RGN_ERAS  = 2'd1,
    RGN_FIXED = 2'd2
  } region_e;
endpackage

// File: rtl/bx_regfile.sv
module bx_regfile
  import bx_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int NR  = NREG,
  parameter int EBW = EB_W,
  parameter int FBW = FB_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic [$clog2(NR)-1:0] idx,
  input  logic [DW-1:0]         wr_data,
  output logic [EBW-1:0]        eb,
  output logic [FBW-1:0]        fb,
  output logic                  sb,
  output logic [DW-1:0]         rd_word
);
  localparam int IW = $clog2(NR);
  localparam logic [IW-1:0] K_EB = IW'(IX_EB);
  localparam logic [IW-1:0] K_FB = IW'(IX_FB);
  localparam logic [IW-1:0] K_BB = IW'(IX_BB);
  localparam logic [IW-1:0] K_SB = IW'(IX_SB);

  logic [EBW-1:0] eb_q;
  logic [FBW-1:0] fb_q;
  logic           sb_q;
  logic [DW-1:0]  gp_q [NR];

  always_ff @(posedge clk) begin
    if (rst) begin
      eb_q <= '0;
      fb_q <= '0;
      sb_q <= 1'b0;
      for (int i = 0; i < NR; i++) gp_q[i] <= '0;
    end else if (wr) begin
      case (idx)
        K_EB: eb_q <= wr_data[EB_LSB +: EBW];
        K_FB: fb_q <= wr_data[FB_LSB +: FBW];
        K_BB: begin
          eb_q <= wr_data[BB_EB_LSB +: EBW];
          fb_q <= wr_data[BB_FB_LSB +: FBW];
        end
        K_SB: sb_q <= wr_data[SB_POS];
        default: gp_q[idx] <= wr_data;
      endcase
    end
  end

  always_comb begin
    rd_word = '0;
    case (idx)
      K_EB: rd_word[EB_LSB +: EBW] = eb_q;
      K_FB: rd_word[FB_LSB +: FBW] = fb_q;
      K_BB: begin
        rd_word[BB_EB_LSB +: EBW] = eb_q;
        rd_word[BB_FB_LSB +: FBW] = fb_q;
      end
      K_SB: rd_word[SB_POS] = sb_q;
      default: rd_word = gp_q[idx];
    endcase
  end

  assign eb = eb_q;
  assign fb = fb_q;
  assign sb = sb_q;
endmodule

// File: rtl/bx_map.sv
module bx_map
  import bx_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int PW    = PHYS_W,
  parameter int EBW   = EB_W,
  parameter int FBW   = FB_W,
  parameter int OFSW  = OFS_W,
  parameter int EOFSW = EOFS_W,
  parameter int RAW   = REG_AW
) (
  input  logic [AW-1:0]  addr,
  input  logic [EBW-1:0] eb,
  input  logic [FBW-1:0] fb,
  input  logic           sb,
  output logic [PW-1:0]  phys,
  output region_e        rgn
);
  localparam int BANK_W = FBW + 1;

  logic [BANK_W-1:0] bank;
  logic              ext_hit;

  // extension applies only to the top four fixed bank codes
  assign ext_hit = sb & (&fb[FBW-1:2]);

  always_comb begin
    bank = {1'b0, fb};
    if (ext_hit) bank = BANK_W'((1 << FBW) + int'(fb[1:0]));
  end

  always_comb begin
    phys = '0;
    rgn  = RGN_ERAS;
    if (addr[AW-1]) begin
      rgn  = RGN_FIXED;
      phys = PW'(addr);
    end else if (addr[OFSW]) begin
      rgn  = RGN_FIXED;
      phys = PW'({bank, addr[OFSW-1:0]});
    end else if (addr[OFSW-1:RAW] == '0) begin
      rgn  = RGN_REG;
      phys = PW'(addr);
    end else if (&addr[OFSW-1:EOFSW]) begin
      phys = PW'({eb, addr[EOFSW-1:0]});
    end else begin
      phys = PW'(addr);
    end
  end
endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
  import bx_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int DW  = DATA_W,
  parameter int PW  = PHYS_W,
  parameter int EBW = EB_W,
  parameter int FBW = FB_W,
  parameter int NR  = NREG
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [11:0]   addr_in,
  input  logic          wr_en,
  input  logic [15:0]   wr_data,
  output logic [15:0]   phys_addr,
  output logic [1:0]    region,
  output logic [15:0]   rd_data
);
  localparam int IW = $clog2(NR);

  logic           is_reg;
  logic [IW-1:0]  idx;
  logic [EBW-1:0] eb;
  logic [FBW-1:0] fb;
  logic           sb;
  logic [DW-1:0]  rd_word;
  logic [PW-1:0]  map_phys;
  region_e        map_rgn;

  assign is_reg = (addr_in[AW-1:IW] == '0);
  assign idx    = addr_in[IW-1:0];

  bx_regfile #(.DW(DW), .NR(NR), .EBW(EBW), .FBW(FBW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr      (wr_en & is_reg),
    .idx     (idx),
    .wr_data (wr_data),
    .eb      (eb),
    .fb      (fb),
    .sb      (sb),
    .rd_word (rd_word)
  );

  bx_map #(.AW(AW), .PW(PW), .EBW(EBW), .FBW(FBW), .RAW(IW)) u_map (
    .addr (addr_in),
    .eb   (eb),
    .fb   (fb),
    .sb   (sb),
    .phys (map_phys),
    .rgn  (map_rgn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_addr <= '0;
      region    <= RGN_REG;
      rd_data   <= '0;
    end else begin
      phys_addr <= map_phys;
      region    <= map_rgn;
      rd_data   <= is_reg ? rd_word : '0;
    end
  end
endmodule

// File: rtl/bank_xlate_chk.sv
module bank_xlate_chk
  import bx_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   addr_in,
  input logic [PHYS_W-1:0]   phys_addr,
  input logic [1:0]          region,
  input logic [DATA_W-1:0]   rd_data
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  p_reset_values_r8: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(rst)) |-> (phys_addr == '0 && region == RGN_REG && rd_data == '0));

  p_low_eras_r2: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst) && $past(addr_in) >= 12'd8 && $past(addr_in) < 12'd768)
      |-> (phys_addr == PHYS_W'($past(addr_in)) && region == RGN_ERAS));

  p_upper_eras_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst) && $past(addr_in) >= 12'd768 && $past(addr_in) < 12'd1024)
      |-> (phys_addr[EOFS_W-1:0] == $past(addr_in[EOFS_W-1:0])
           && phys_addr[PHYS_W-1:EOFS_W+EB_W] == '0 && region == RGN_ERAS));

  p_window_ofs_r4: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst) && $past(addr_in) >= 12'd1024 && $past(addr_in) < 12'd2048)
      |-> (phys_addr[OFS_W-1:0] == $past(addr_in[OFS_W-1:0])
           && int'(phys_addr[PHYS_W-1:OFS_W]) < N_FBANKS && region == RGN_FIXED));

  p_fixed_fixed_r6: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst) && $past(addr_in[ADDR_W-1]))
      |-> (phys_addr == PHYS_W'($past(addr_in)) && region == RGN_FIXED));

  p_reg_region_r7: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst) && $past(addr_in) < 12'd8)
      |-> (phys_addr == PHYS_W'($past(addr_in)) && region == RGN_REG));

  p_region_legal_r7: assert property (@(posedge clk) disable iff (rst)
    armed |-> (region != 2'd3));

  p_rd_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (armed && region != RGN_REG) |-> (rd_data == '0));
endmodule

bind bank_xlate bank_xlate_chk u_chk (.*);

// File: tb/bank_xlate_test.sv
module bank_xlate_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst;
  logic [11:0] addr;
  logic        we;
  logic [15:0] wd;
  logic [15:0] phys_addr;
  logic [1:0]  region;
  logic [15:0] rd_data;

  bank_xlate uut (
    .clk(clk), .rst(rst), .addr_in(addr), .wr_en(we), .wr_data(wd),
    .phys_addr(phys_addr), .region(region), .rd_data(rd_data)
  );

  typedef struct {
    logic [11:0] a;
    logic [15:0] phys;
    logic [1:0]  rgn;
    logic [15:0] rd;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic [2:0]  m_eb;
  logic [4:0]  m_fb;
  logic        m_sb;
  logic [15:0] m_gp [8];

  function automatic logic [17:0] ref_map(input logic [11:0] a);
    int p; int bank; logic [1:0] r;
    if (a >= 2048) begin r = 2; p = a; end
    else if (a >= 1024) begin
      bank = (m_sb && m_fb >= 28) ? m_fb + 4 : m_fb;
      r = 2; p = bank * 1024 + (a % 1024);
    end
    else if (a < 8) begin r = 0; p = a; end
    else if (a >= 768) begin r = 1; p = m_eb * 256 + (a % 256); end
    else begin r = 1; p = a; end
    return {r, 16'(p)};
  endfunction

  function automatic logic [15:0] ref_rd(input logic [11:0] a);
    if (a >= 8) return 16'h0;
    case (a)
      3: return 16'(m_eb) << 8;
      4: return 16'(m_fb) << 10;
      6: return (16'(m_fb) << 10) | 16'(m_eb);
      7: return 16'(m_sb) << 6;
      default: return m_gp[a];
    endcase
  endfunction

  task automatic drive(input logic [11:0] a, input logic w, input logic [15:0] d,
                       input string tag);
    item_t it;
    logic [17:0] m;
    @(negedge clk);
    addr = a; we = w; wd = d;
    m = ref_map(a);
    it.a = a; it.rgn = m[17:16]; it.phys = m[15:0]; it.rd = ref_rd(a); it.tag = tag;
    q.push_back(it);
    if (w && a < 8) begin
      case (a)
        3: m_eb = d[10:8];
        4: m_fb = d[14:10];
        6: begin m_fb = d[14:10]; m_eb = d[2:0]; end
        7: m_sb = d[6];
        default: m_gp[a] = d;
      endcase
    end
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    drive(a, 1'b0, 16'h0, tag);
  endtask

  // monitor: compares each result one edge after its address was driven
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (phys_addr !== it.phys || region !== it.rgn || rd_data !== it.rd) begin
          fails++;
          $display("FAIL %s addr=%0d phys=%0h exp=%0h region=%0d exp=%0d rd=%0h exp=%0h",
                   it.tag, it.a, phys_addr, it.phys, region, it.rgn, rd_data, it.rd);
        end
      end
    end
  end

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; addr = 12'd0; we = 1'b0; wd = 16'h0;
    m_eb = 0; m_fb = 0; m_sb = 0;
    for (int i = 0; i < 8; i++) m_gp[i] = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset output state
    checks++;
    if (phys_addr !== 16'h0 || region !== 2'd0 || rd_data !== 16'h0) begin
      fails++;
      $display("FAIL R8 reset outputs phys=%0h region=%0d rd=%0h exp=0/0/0",
               phys_addr, region, rd_data);
    end
    rst = 1'b0;

    // R8: all register words read zero after reset
    for (int i = 0; i < 8; i++) rd(12'(i), "R8");

    // R12 and R9: write then read general words
    drive(12'd0, 1'b1, 16'h1234, "R12");
    rd(12'd0, "R9");
    drive(12'd1, 1'b1, 16'hBEEF, "R12");
    drive(12'd2, 1'b1, 16'h8001, "R12");
    drive(12'd5, 1'b1, 16'h7FFE, "R12");
    rd(12'd1, "R9"); rd(12'd2, "R9"); rd(12'd5, "R9");

    // R10: combined bank write and single-field writes
    drive(12'd6, 1'b1, {1'b1, 5'd21, 7'h7F, 3'd5}, "R10");
    rd(12'd3, "R10"); rd(12'd4, "R10"); rd(12'd6, "R10");
    drive(12'd3, 1'b1, 16'hFAFF & 16'hF2FF, "R10");
    rd(12'd6, "R10");
    drive(12'd4, 1'b1, 16'h2C00, "R10");
    rd(12'd6, "R10"); rd(12'd3, "R10");
    drive(12'd7, 1'b1, 16'hFFBF, "R9");
    rd(12'd7, "R9");
    drive(12'd7, 1'b1, 16'h0040, "R12");
    rd(12'd7, "R9");

    // R11: writes outside the register range change nothing
    drive(12'd8, 1'b1, 16'hFFFF, "R11");
    drive(12'd100, 1'b1, 16'hFFFF, "R11");
    drive(12'd1500, 1'b1, 16'hFFFF, "R11");
    drive(12'd3000, 1'b1, 16'hFFFF, "R11");
    for (int i = 0; i < 8; i++) rd(12'(i), "R11");

    // R3 and R2 across every erasable bank
    for (int e = 0; e < 8; e++) begin
      drive(12'd6, 1'b1, {1'b0, m_fb, 7'h0, 3'(e)}, "R10");
      rd(12'd768, "R3 R7");
      rd(12'(768 + ((e * 37) % 256)), "R3");
      rd(12'd1023, "R3");
      rd(12'd767, "R2 R7");
      rd(12'(8 + e * 90), "R2");
    end

    // R4 and R5 across every fixed bank with the extension bit off and on
    for (int s = 0; s < 2; s++) begin
      drive(12'd7, 1'b1, 16'(s) << 6, "R9");
      for (int f = 0; f < 32; f++) begin
        drive(12'd4, 1'b1, 16'(f) << 10, "R10");
        rd(12'd1024, (s == 1 && f >= 28) ? "R5" : "R4 R7");
        rd(12'(1024 + ((f * 29) % 1024)), (s == 1 && f >= 28) ? "R5" : "R4");
        rd(12'd2047, (s == 1 && f >= 28) ? "R5" : "R4");
      end
    end

    // R6: fixed-fixed range ignores bank values
    rd(12'd2048, "R6 R7"); rd(12'd3071, "R6"); rd(12'd3072, "R6"); rd(12'd4095, "R6");
    drive(12'd6, 1'b1, {1'b0, 5'd3, 7'h0, 3'd6}, "R10");
    drive(12'd7, 1'b1, 16'h0000, "R12");
    rd(12'd2048, "R6"); rd(12'd4095, "R6");

    // R1: back-to-back addresses of different regions
    rd(12'd5, "R1"); rd(12'd2050, "R1"); rd(12'd800, "R1");
    rd(12'd1100, "R1"); rd(12'd3, "R1"); rd(12'd20, "R1");
    drive(12'd6, 1'b1, {1'b0, 5'd30, 7'h0, 3'd1}, "R1");
    rd(12'd1025, "R1"); rd(12'd769, "R1"); rd(12'd6, "R1");

    we = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    summary();
    $finish;
  end
endmodule